// File: doc/BRIEF.md
# Reciprocal Square-Root Estimate Unit

This block takes one IEEE-754 double-precision operand and returns a double that estimates 1/sqrt(x). The estimate is meant to be bit-exact against a fixed-table hardware estimate, so it does not round a true result. The mantissa comes from a 32-segment piecewise-linear table. Each segment holds a 26-bit starting value and an 11-bit slope. The low or high half of the table is picked by the parity of the operand's biased exponent. Inside a segment, the fraction is interpolated over 11 mantissa bits.

Subnormal operands are normalised in a single pass, using a leading-zero count and a shifter. The result exponent is then formed by halving. Zeros, infinities, NaNs and negative operands each return a fixed special result, and these differ from an IEEE reciprocal square root. Two flags come with every result: invalid-operation for negative operands and divide-by-zero for zero operands. The result and flags are registered and appear one cycle after an accepted operand.

Top module: `rsqrt_est`

## Requirements
- R1: An operand of +0 or -0 gives infinity with the operand's sign (exponent field 0x7FF, fraction 0) and raises the divide-by-zero flag; invalid-operation stays low.
- R2: +infinity gives +0 with both flags low. -infinity gives the default quiet NaN 0x7FF8000000000000 and raises invalid-operation.
- R3: A NaN operand (exponent 0x7FF, non-zero fraction) is returned with its sign and payload unchanged, except that fraction bit 51 is forced to one. Both flags stay low.
- R4: Any negative operand that is not a zero, an infinity or a NaN gives 0x7FF8000000000000 and raises invalid-operation. This includes negative subnormals.
- R5: A subnormal operand (exponent field 0, non-zero fraction) is normalised first. With k the shift that moves the top set fraction bit to bit 52, the working exponent is 1-k and the working fraction is the shifted value with bit 52 dropped.
- R6: With e the signed working exponent, the result exponent field is floor((3068 - e) / 2), and the result sign is 0.
- R7: The table index is fraction bits [51:48] plus 16 when bit 0 of e is zero, and plus 0 when it is one.
- R8: The result fraction is (base[index] - slope[index] * fraction[47:37]) shifted left by 26. Entry 0 has base 0x3FFA000 and slope 0x7A4. Entry 16 has base 0x1A7E800 and slope 0x568.
- R9: out_valid is high exactly one cycle after in_valid is high. While in_valid is low, out_valid goes low and the result and flags hold their last values.
- R10: After reset, out_valid, out_result and both flags read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand is presented this cycle |
| in_op | input | 64 | Double-precision operand |
| out_valid | output | 1 | Result registered from the previous cycle's operand |
| out_result | output | 64 | Double-precision estimate |
| out_invalid | output | 1 | Invalid-operation flag for this result |
| out_divzero | output | 1 | Divide-by-zero flag for this result |

## Verification
The bench targets the exponent-parity seam. It uses 1.0 against 2.0, and the largest finite exponent, where a parity error would select the wrong half of the table and give a result off by about a factor of sqrt(2). It applies interpolation offsets of 0, 1 and 2047 inside a segment, which expose a wrong slope or a shifted fraction field. Subnormals are tested with the top set bit at 0, 30, 46 and 51, where a leading-zero count that is off by one would shift the fraction wrongly and move the exponent. The special operands are tested with both signs, including signalling NaNs and negative subnormals, where a wrong classification priority would return the default NaN for +infinity or skip the quiet-bit fix.

// File: rtl/rsqe_pkg.sv
package rsqe_pkg;
  localparam int DW      = 64;
  localparam int EW      = 11;
  localparam int FW      = 52;
  localparam int SEG_W   = 4;
  localparam int OFS_W   = 11;
  localparam int IDX_W   = SEG_W + 1;
  localparam int BASE_W  = 26;
  localparam int SLOPE_W = 11;
  localparam int PROD_W  = SLOPE_W + OFS_W;
  localparam int FSHIFT  = FW - BASE_W;
  localparam int ESW     = EW + 2;
  localparam int LZ_W    = $clog2(FW + 1);
  localparam int SEG_LSB = FW - SEG_W;
  localparam int OFS_LSB = SEG_LSB - OFS_W;
  localparam int EXP_BIAS_SUM = 3068;

  localparam logic [EW-1:0] EXP_ONES = '1;
  localparam logic [DW-1:0] DEFAULT_QNAN = {1'b0, EXP_ONES, 1'b1, {(FW-1){1'b0}}};

  typedef enum logic [2:0] {
    OPC_NUMBER,
    OPC_ZERO,
    OPC_POS_INF,
    OPC_NEG_INF,
    OPC_NAN,
    OPC_NEGATIVE
  } op_class_e;

  typedef struct packed {
    logic [BASE_W-1:0]  base;
    logic [SLOPE_W-1:0] slope;
  } seg_entry_t;

  // Segment table: entries 0..15 serve an odd biased exponent, 16..31 an even one.
  function automatic seg_entry_t seg_lookup(input logic [IDX_W-1:0] idx);
    seg_entry_t s;
    case (idx)
      5'd0:  s = '{26'h3FFA000, 11'h7A4};
      5'd1:  s = '{26'h3C29000, 11'h700};
      5'd2:  s = '{26'h38AA000, 11'h670};
      5'd3:  s = '{26'h3572000, 11'h5F2};
      5'd4:  s = '{26'h3279000, 11'h584};
      5'd5:  s = '{26'h2FB7000, 11'h524};
      5'd6:  s = '{26'h2D26000, 11'h4CC};
      5'd7:  s = '{26'h2AC0000, 11'h47E};
      5'd8:  s = '{26'h2881000, 11'h43A};
      5'd9:  s = '{26'h2665000, 11'h3FA};
      5'd10: s = '{26'h2468000, 11'h3C2};
      5'd11: s = '{26'h2287000, 11'h38E};
      5'd12: s = '{26'h20C1000, 11'h35E};
      5'd13: s = '{26'h1F12000, 11'h332};
      5'd14: s = '{26'h1D79000, 11'h30A};
      5'd15: s = '{26'h1BF4000, 11'h2E6};
      5'd16: s = '{26'h1A7E800, 11'h568};
      5'd17: s = '{26'h17CB800, 11'h4F3};
      5'd18: s = '{26'h1552800, 11'h48D};
      5'd19: s = '{26'h130C000, 11'h435};
      5'd20: s = '{26'h10F2000, 11'h3E7};
      5'd21: s = '{26'h0EFF000, 11'h3A2};
      5'd22: s = '{26'h0D2E000, 11'h365};
      5'd23: s = '{26'h0B7C000, 11'h32E};
      5'd24: s = '{26'h09E5000, 11'h2FC};
      5'd25: s = '{26'h0867000, 11'h2D0};
      5'd26: s = '{26'h06FF000, 11'h2A8};
      5'd27: s = '{26'h05AB800, 11'h283};
      5'd28: s = '{26'h046A000, 11'h261};
      5'd29: s = '{26'h0339800, 11'h243};
      5'd30: s = '{26'h0218800, 11'h226};
      default: s = '{26'h0105800, 11'h20B};
    endcase
    return s;
  endfunction

  // Halved exponent: floor((3068 - e) / 2); the difference is always positive.
  function automatic logic [EW-1:0] halve_exponent(input logic signed [ESW-1:0] e);
    logic signed [ESW:0] diff;
    diff = (ESW+1)'(EXP_BIAS_SUM) - {e[ESW-1], e};
    return diff[EW:1];
  endfunction

  // Linear interpolation inside one segment, placed at the top of the fraction.
  function automatic logic [FW-1:0] interp_fraction(input seg_entry_t s,
                                                    input logic [OFS_W-1:0] ofs);
    logic [PROD_W-1:0] prod;
    logic [BASE_W-1:0] diff;
    prod = PROD_W'(s.slope) * PROD_W'(ofs);
    diff = s.base - BASE_W'(prod);
    return {diff, {FSHIFT{1'b0}}};
  endfunction

  // Leading zeros of a fraction field; all-zero returns FW.
  function automatic logic [LZ_W-1:0] count_lead_zeros(input logic [FW-1:0] f);
    logic [LZ_W-1:0] n;
    n = LZ_W'(FW);
    for (int b = 0; b < FW; b++) begin
      if (f[b]) n = LZ_W'(FW - 1 - b);
    end
    return n;
  endfunction
endpackage

// File: rtl/rsqe_classify.sv
module rsqe_classify
  import rsqe_pkg::*;
(
  input  logic [DW-1:0] op,
  output op_class_e     op_class,
  output logic          op_sign,
  output logic [EW-1:0] op_exp,
  output logic [FW-1:0] op_frac,
  output logic          op_subnormal
);
  logic exp_zero, exp_max, frac_zero;

  assign op_sign   = op[DW-1];
  assign op_exp    = op[DW-2 -: EW];
  assign op_frac   = op[FW-1:0];
  assign exp_zero  = (op_exp == '0);
  assign exp_max   = (op_exp == EXP_ONES);
  assign frac_zero = (op_frac == '0);
  assign op_subnormal = exp_zero && !frac_zero;

  // Priority order matters: zeros and the all-ones exponent are decided before sign.
  always_comb begin
    if (exp_zero && frac_zero)      op_class = OPC_ZERO;
    else if (exp_max && frac_zero)  op_class = op_sign ? OPC_NEG_INF : OPC_POS_INF;
    else if (exp_max)               op_class = OPC_NAN;
    else if (op_sign)               op_class = OPC_NEGATIVE;
    else                            op_class = OPC_NUMBER;
  end
endmodule

// File: rtl/rsqe_normalize.sv
module rsqe_normalize
  import rsqe_pkg::*;
(
  input  logic                  subnormal,
  input  logic [EW-1:0]         exp_in,
  input  logic [FW-1:0]         frac_in,
  output logic signed [ESW-1:0] work_exp,
  output logic [FW-1:0]         work_frac,
  output logic [LZ_W-1:0]       shift_amt
);
  logic [LZ_W-1:0] lead_zeros;
  logic [FW:0]     shifted;

  assign lead_zeros = count_lead_zeros(frac_in);
  assign shift_amt  = subnormal ? lead_zeros + LZ_W'(1) : '0;
  assign shifted    = {1'b0, frac_in} << shift_amt;

  always_comb begin
    if (subnormal) begin
      work_exp  = ESW'(signed'(1)) - $signed({{(ESW-LZ_W){1'b0}}, shift_amt});
      work_frac = shifted[FW-1:0];
    end else begin
      work_exp  = $signed({2'b00, exp_in});
      work_frac = frac_in;
    end
  end
endmodule

// File: rtl/rsqe_interp.sv
module rsqe_interp
  import rsqe_pkg::*;
(
  input  logic signed [ESW-1:0] work_exp,
  input  logic [FW-1:0]         work_frac,
  output logic                  even_exp,
  output logic [IDX_W-1:0]      tbl_idx,
  output logic [OFS_W-1:0]      tbl_ofs,
  output logic [EW-1:0]         res_exp,
  output logic [FW-1:0]         res_frac
);
  seg_entry_t entry;

  assign even_exp = ~work_exp[0];
  assign tbl_idx  = {even_exp, work_frac[FW-1 -: SEG_W]};
  assign tbl_ofs  = work_frac[SEG_LSB-1 -: OFS_W];
  assign entry    = seg_lookup(tbl_idx);
  assign res_exp  = halve_exponent(work_exp);
  assign res_frac = interp_fraction(entry, tbl_ofs);
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsqe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [63:0]   in_op,
  output logic          out_valid,
  output logic [63:0]   out_result,
  output logic          out_invalid,
  output logic          out_divzero
);
  op_class_e             op_class;
  logic                  op_sign;
  logic [EW-1:0]         op_exp;
  logic [FW-1:0]         op_frac;
  logic                  op_subnormal;
  logic signed [ESW-1:0] work_exp;
  logic [FW-1:0]         work_frac;
  logic [LZ_W-1:0]       shift_amt;
  logic                  even_exp;
  logic [IDX_W-1:0]      tbl_idx;
  logic [OFS_W-1:0]      tbl_ofs;
  logic [EW-1:0]         res_exp;
  logic [FW-1:0]         res_frac;

  logic [DW-1:0] next_result;
  logic          next_invalid;
  logic          next_divzero;

  rsqe_classify u_classify (
    .op           (in_op),
    .op_class     (op_class),
    .op_sign      (op_sign),
    .op_exp       (op_exp),
    .op_frac      (op_frac),
    .op_subnormal (op_subnormal)
  );

  rsqe_normalize u_normalize (
    .subnormal (op_subnormal),
    .exp_in    (op_exp),
    .frac_in   (op_frac),
    .work_exp  (work_exp),
    .work_frac (work_frac),
    .shift_amt (shift_amt)
  );

  rsqe_interp u_interp (
    .work_exp  (work_exp),
    .work_frac (work_frac),
    .even_exp  (even_exp),
    .tbl_idx   (tbl_idx),
    .tbl_ofs   (tbl_ofs),
    .res_exp   (res_exp),
    .res_frac  (res_frac)
  );

  always_comb begin
    next_invalid = 1'b0;
    next_divzero = 1'b0;
    unique case (op_class)
      OPC_ZERO: begin
        next_result  = {op_sign, EXP_ONES, {FW{1'b0}}};
        next_divzero = 1'b1;
      end
      OPC_POS_INF:  next_result = '0;
      OPC_NEG_INF: begin
        next_result  = DEFAULT_QNAN;
        next_invalid = 1'b1;
      end
      OPC_NAN:      next_result = in_op | (DW'(1) << (FW - 1));
      OPC_NEGATIVE: begin
        next_result  = DEFAULT_QNAN;
        next_invalid = 1'b1;
      end
      default:      next_result = {1'b0, res_exp, res_frac};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_divzero <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= next_result;
        out_invalid <= next_invalid;
        out_divzero <= next_divzero;
      end
    end
  end
endmodule

// File: rtl/rsqrt_est_checker.sv
module rsqrt_est_checker
  import rsqe_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic [63:0]           out_result,
  input logic                  out_invalid,
  input logic                  out_divzero,
  input logic                  op_subnormal,
  input logic signed [ESW-1:0] work_exp,
  input logic [IDX_W-1:0]      tbl_idx
);
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_invalid)));

  p_zero_gives_inf_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_divzero |-> (out_result[62:0] == {EXP_ONES, {FW{1'b0}}} && !out_invalid));

  p_invalid_nan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> (out_result == DEFAULT_QNAN));

  p_subnormal_exp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_subnormal |-> (work_exp <= 0));

  p_table_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (work_exp[0] == 1'b0) |-> tbl_idx[IDX_W-1]);
endmodule

bind rsqrt_est rsqrt_est_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .out_result   (out_result),
  .out_invalid  (out_invalid),
  .out_divzero  (out_divzero),
  .op_subnormal (op_subnormal),
  .work_exp     (work_exp),
  .tbl_idx      (tbl_idx)
);

// File: tb/rsqrt_est_test.sv
module rsqrt_est_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_op = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_invalid;
  logic        out_divzero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsqrt_est uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_invalid (out_invalid),
    .out_divzero (out_divzero)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Bench model built from the requirement text; only table entries 0 and 16 are known here.
  function automatic logic [63:0] model(input logic [63:0] x, output logic inv, output logic dz);
    logic        s;
    logic [10:0] ex;
    logic [51:0] f;
    int          e;
    int          idx;
    longint      base, slope, ofs, frac;
    s = x[63]; ex = x[62:52]; f = x[51:0];
    inv = 1'b0; dz = 1'b0;
    if (ex == 0 && f == 0) begin dz = 1'b1; return {s, 11'h7FF, 52'd0}; end
    if (ex == 11'h7FF && f == 0) begin
      if (s) begin inv = 1'b1; return QNAN; end
      return 64'd0;
    end
    if (ex == 11'h7FF) return {x[63:52], 1'b1, x[50:0]};
    if (s) begin inv = 1'b1; return QNAN; end
    e = int'(ex);
    if (ex == 0) begin
      while (f[51] == 1'b0) begin f = f << 1; e = e - 1; end
      f = f << 1;
    end
    idx = ((e % 2 == 0) ? 16 : 0) + int'(f[51:48]);
    ofs = longint'(f[47:37]);
    if (idx == 0) begin base = 64'h3FFA000; slope = 64'h7A4; end
    else if (idx == 16) begin base = 64'h1A7E800; slope = 64'h568; end
    else return 64'hxxxxxxxxxxxxxxxx;
    frac = base - slope * ofs;
    return {1'b0, 11'((3068 - e) / 2), 26'(frac), 26'd0};
  endfunction

  task automatic apply_and_check(input string req, input logic [63:0] x);
    logic [63:0] exp;
    logic inv, dz;
    exp = model(x, inv, dz);
    @(negedge clk);
    in_valid = 1'b1;
    in_op = x;
    @(negedge clk);
    in_valid = 1'b0;
    in_op = ~x;
    check(req, $sformatf("valid for %h", x), 64'(out_valid), 64'd1);
    check(req, $sformatf("result for %h", x), out_result, exp);
    check(req, $sformatf("invalid for %h", x), 64'(out_invalid), 64'(inv));
    check(req, $sformatf("divzero for %h", x), 64'(out_divzero), 64'(dz));
  endtask

  task automatic t_reset_state();
    check("R10", "out_valid", 64'(out_valid), 64'd0);
    check("R10", "out_result", out_result, 64'd0);
    check("R10", "flags", {62'd0, out_invalid, out_divzero}, 64'd0);
  endtask

  task automatic t_zeros();
    apply_and_check("R1", 64'h0000000000000000);
    check("R1", "+0 literal", out_result, 64'h7FF0000000000000);
    apply_and_check("R1", 64'h8000000000000000);
    check("R1", "-0 literal", out_result, 64'hFFF0000000000000);
  endtask

  task automatic t_infinities();
    apply_and_check("R2", 64'h7FF0000000000000);
    apply_and_check("R2", 64'hFFF0000000000000);
    check("R2", "-inf literal", out_result, QNAN);
  endtask

  task automatic t_nans();
    apply_and_check("R3", 64'h7FF0000000000001);
    check("R3", "quieted literal", out_result, 64'h7FF8000000000001);
    apply_and_check("R3", 64'hFFF4000000000ABC);
    apply_and_check("R3", 64'h7FFC000000000000);
  endtask

  task automatic t_negatives();
    apply_and_check("R4", 64'hBFF0000000000000);
    apply_and_check("R4", 64'h8000000000000005);
    apply_and_check("R4", 64'hFFEFFFFFFFFFFFFF);
  endtask

  task automatic t_parity_and_table();
    apply_and_check("R7", 64'h3FF0000000000000);
    check("R8", "1.0 literal", out_result, {1'b0, 11'h3FE, 26'h3FFA000, 26'd0});
    apply_and_check("R7", 64'h4000000000000000);
    check("R8", "2.0 literal", out_result, {1'b0, 11'h3FE, 26'h1A7E800, 26'd0});
    apply_and_check("R6", 64'h7FE0000000000000);
    apply_and_check("R6", 64'h0010000000000000);
  endtask

  task automatic t_interp_offsets();
    apply_and_check("R8", 64'h3FF0002000000ABC);
    apply_and_check("R8", 64'h3FF0FFE000000000);
    apply_and_check("R8", 64'h4000FFE000000000);
    apply_and_check("R8", 64'h4010004000000000);
  endtask

  task automatic t_subnormals();
    apply_and_check("R5", 64'h0000000000000001);
    check("R5", "min subnormal exponent", 64'(out_result[62:52]), 64'h617);
    apply_and_check("R5", 64'h0008000000000000);
    check("R5", "top-bit subnormal", out_result, {1'b0, 11'h5FE, 26'h1A7E800, 26'd0});
    apply_and_check("R5", 64'h0000400000000000);
    apply_and_check("R5", 64'h0000000040300000);
  endtask

  task automatic t_idle_hold();
    logic [63:0] held;
    apply_and_check("R9", 64'h3FF0000000000000);
    held = out_result;
    @(negedge clk);
    in_op = 64'h0000000000000000;
    @(negedge clk);
    check("R9", "valid low when idle", 64'(out_valid), 64'd0);
    check("R9", "result held when idle", out_result, held);
    check("R9", "divzero held when idle", 64'(out_divzero), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_zeros();
    t_infinities();
    t_nans();
    t_negatives();
    t_parity_and_table();
    t_interp_offsets();
    t_subnormals();
    t_idle_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule